// File: doc/BRIEF.md
# CCD Readout Clock Sequencer

This block produces the digital drive pattern for a two-phase full-frame CCD: a complementary vertical clock pair, the transfer gate, a complementary horizontal clock pair, the summing gate and the per-pixel reset gate. It also drives a shutter-open output and a strobe that marks the cycle in which an image pixel can be sampled. A single `start` pulse runs one frame. The frame is an integration period with the shutter open, then vertical transfers, then horizontal readout. A one-cycle `frame_done` pulse closes the frame.

Two readout modes exist. In binning mode every row is shifted into the horizontal register before one line is read out. In area mode each row is shifted and then read out in full before the next row moves. Two select inputs choose the device geometry: short or tall (rows) and narrow or wide (columns). Every pulse width and gap is a parameter counted in system-clock cycles. The vertical pulse width grows with device size. Mode and geometry are captured at `start`.

Top module: `ccd_clock_sequencer`

## Requirements
- R1: In reset and whenever idle, the outputs are `vclk_a`=1, `vclk_b`=0, `xfer_gate`=0, `hclk_a`=0, `hclk_b`=1, `sum_gate`=1, `rst_gate`=0, `shutter_open`=0, `pix_valid`=0 and `frame_done`=0. A reset in the middle of a frame returns the block to that state on the next clock.
- R2: `shutter_open` is high for exactly max(`integ_len`,1) cycles, beginning in the cycle after `start` is taken. No vertical or horizontal clock pulse occurs while it is high.
- R3: `vclk_a` is always the inverse of `vclk_b`, and `xfer_gate` always equals `vclk_b`. `hclk_b` is always the inverse of `hclk_a`, and `sum_gate` always equals `hclk_b`.
- R4: A frame makes EFF_ROWS + BEVEL_ROWS vertical transfers, using the short or tall row count selected by `tall_dev`. Each transfer is one high pulse on `vclk_b` of V_HALF_BASE × 2^(`tall_dev`+`wide_dev`) cycles, followed by the same number of low cycles.
- R5: A line is LEAD_DUMMY + EFF_COLS + TRAIL_DUMMY + 1 pixels, using the narrow or wide column count selected by `wide_dev`. Each pixel is H_HALF cycles with `hclk_a` high, then H_HALF cycles with it low.
- R6: `rst_gate` pulses once per pixel. It is high for RG_WIDTH cycles starting in the first high cycle of `hclk_a`.
- R7: In binning mode (`area_mode`=0), all vertical transfers complete before the first `hclk_a` rise, and exactly one line is read.
- R8: In area mode (`area_mode`=1), each vertical transfer is followed by one complete line before the next transfer.
- R9: The first `hclk_a` rise after a `xfer_gate` fall comes after exactly V_HALF + TG_GAP cycles with `xfer_gate` low.
- R10: `pix_valid` is one cycle wide, in the last cycle of each pixel. It fires only for line positions LEAD_DUMMY+1 to LEAD_DUMMY+EFF_COLS (1-based). In area mode it is also suppressed on the first BEVEL_ROWS rows read.
- R11: `frame_done` is one cycle wide. It arrives in cycle L + R·2V + TG_GAP + P·2H + 1 after `start` in binning mode, and in cycle L + R·(2V + TG_GAP + P·2H) + 1 in area mode. Here L is the shutter length, R the transfers, P the pixels per line, V the vertical half width and H = H_HALF.
- R12: `start`, `area_mode`, `tall_dev` and `wide_dev` are ignored while a frame is running. The frame in progress keeps its length and counts, and no second frame follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a frame (taken only when idle) |
| integ_len | input | INTEG_W | Shutter-open length in cycles (0 acts as 1) |
| area_mode | input | 1 | 0 = line binning, 1 = area readout |
| tall_dev | input | 1 | 0 = short row count, 1 = tall row count |
| wide_dev | input | 1 | 0 = narrow line, 1 = wide line |
| vclk_a | output | 1 | Vertical clock phase A |
| vclk_b | output | 1 | Vertical clock phase B |
| xfer_gate | output | 1 | Transfer gate, follows phase B |
| hclk_a | output | 1 | Horizontal clock phase A |
| hclk_b | output | 1 | Horizontal clock phase B |
| sum_gate | output | 1 | Summing gate, follows horizontal phase B |
| rst_gate | output | 1 | Output-node reset pulse, one per pixel |
| shutter_open | output | 1 | High during integration only |
| pix_valid | output | 1 | Image-pixel sample strobe |
| frame_done | output | 1 | One-cycle end-of-frame pulse |

## Verification
A row counter that is off by one shows within one frame: the count of `vclk_b` pulses is wrong, and in area mode the line after the error shifts the `pix_valid` window by a whole line of `hclk_a` rises. A pixel counter or phase-generator error changes the `hclk_a` rise count and the `frame_done` cycle by at least one pixel period. A broken mode or geometry latch shows when inputs are toggled in mid-frame: `frame_done` then arrives in the wrong cycle, or a second `shutter_open` period appears right after the first frame.

// File: rtl/ccd_seq_pkg.sv
// Shared types for the CCD clock sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package ccd_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_INTEG = 3'd1,
        ST_VXFER = 3'd2,
        ST_GAP   = 3'd3,
        ST_HREAD = 3'd4,
        ST_DONE  = 3'd5
    } seq_state_t;
endpackage

// File: rtl/ccd_vphase_gen.sv
// One vertical transfer: phase high for half_w cycles, then low for half_w
// cycles. 'last' marks the final low cycle so a new go may follow at once.
// Assumes: half_w >= 1, and go only when idle or in the last cycle.
module ccd_vphase_gen #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [CW-1:0] half_w,
    output logic          ph,
    output logic          last
);
    logic          active;
    logic [CW:0]   cnt;
    logic [CW-1:0] w_q;

    // Down-counter over one full transfer period; width captured at go.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            cnt    <= '0;
            w_q    <= '0;
        end else if (go) begin
            active <= 1'b1;
            cnt    <= {half_w, 1'b0} - 1'b1;
            w_q    <= half_w;
        end else if (active) begin
            if (cnt == '0) active <= 1'b0;
            else           cnt    <= cnt - 1'b1;
        end
    end

    // Upper half of the count is the high phase.
    assign ph   = active && (cnt >= {1'b0, w_q});
    assign last = active && (cnt == '0);

    // R4
    vgo_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> (!active || last));
endmodule

// File: rtl/ccd_hphase_gen.sv
// One pixel period: phase high for HALF_W cycles, then low for HALF_W
// cycles. A reset-gate pulse of RG_W cycles opens the high phase.
// Assumes: 1 <= RG_W <= HALF_W; go only when idle or in the last cycle.
module ccd_hphase_gen #(
    parameter int HALF_W = 2,
    parameter int RG_W   = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    output logic ph,
    output logic rg,
    output logic last
);
    localparam int CW = (2 * HALF_W > 2) ? $clog2(2 * HALF_W) : 1;
    localparam logic [CW-1:0] LOAD   = CW'(2 * HALF_W - 1);
    localparam logic [CW-1:0] HI_THR = CW'(HALF_W);
    localparam logic [CW-1:0] RG_THR = CW'(2 * HALF_W - RG_W);

    logic          active;
    logic [CW-1:0] cnt;

    // Down-counter over one pixel period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (go) begin
            active <= 1'b1;
            cnt    <= LOAD;
        end else if (active) begin
            if (cnt == '0) active <= 1'b0;
            else           cnt    <= cnt - 1'b1;
        end
    end

    // Decode the phase, the reset-gate window and the period end.
    assign ph   = active && (cnt >= HI_THR);
    assign rg   = active && (cnt >= RG_THR);
    assign last = active && (cnt == '0);

    // R5
    hgo_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> (!active || last));
    // R6
    rg_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ph) |-> rg);
endmodule

// File: rtl/ccd_clock_sequencer.sv
// Frame sequencer for a two-phase full-frame CCD. It runs integration,
// vertical transfers and horizontal readout in binning or area order.
// Assumes: synchronous active-low reset; V_HALF_BASE, H_HALF, TG_GAP >= 1;
// RG_WIDTH <= H_HALF; mode and geometry are sampled when start is taken.
module ccd_clock_sequencer
    import ccd_seq_pkg::*;
#(
    parameter int EFF_COLS_NARROW = 512,
    parameter int EFF_COLS_WIDE   = 1024,
    parameter int EFF_ROWS_SHORT  = 58,
    parameter int EFF_ROWS_TALL   = 122,
    parameter int BEVEL_ROWS      = 6,
    parameter int LEAD_DUMMY      = 10,
    parameter int TRAIL_DUMMY     = 9,
    parameter int V_HALF_BASE     = 500,
    parameter int H_HALF          = 500,
    parameter int RG_WIDTH        = 25,
    parameter int TG_GAP          = 750,
    parameter int INTEG_W         = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [INTEG_W-1:0] integ_len,
    input  logic               area_mode,
    input  logic               tall_dev,
    input  logic               wide_dev,
    output logic               vclk_a,
    output logic               vclk_b,
    output logic               xfer_gate,
    output logic               hclk_a,
    output logic               hclk_b,
    output logic               sum_gate,
    output logic               rst_gate,
    output logic               shutter_open,
    output logic               pix_valid,
    output logic               frame_done
);
    localparam int LINE_NARROW = LEAD_DUMMY + EFF_COLS_NARROW + TRAIL_DUMMY + 1;
    localparam int LINE_WIDE   = LEAD_DUMMY + EFF_COLS_WIDE + TRAIL_DUMMY + 1;
    localparam int ROWS_SHORT  = EFF_ROWS_SHORT + BEVEL_ROWS;
    localparam int ROWS_TALL   = EFF_ROWS_TALL + BEVEL_ROWS;
    localparam int PIX_CW      = $clog2(LINE_WIDE + 1);
    localparam int ROW_CW      = $clog2(ROWS_TALL + 1);
    localparam int VW_CW       = $clog2(4 * V_HALF_BASE + 1);
    localparam int GAP_CW      = $clog2(TG_GAP + 1);

    seq_state_t          state_q;
    logic                area_q, tall_q, wide_q;
    logic [INTEG_W-1:0]  icnt;
    logic [ROW_CW-1:0]   row_cnt;
    logic [PIX_CW-1:0]   pix_cnt;
    logic [GAP_CW-1:0]   gcnt;

    logic [ROW_CW-1:0]   n_rows;
    logic [PIX_CW-1:0]   line_len, eff_cols;
    logic [VW_CW-1:0]    v_half;
    logic                v_ph, v_last, h_ph, h_rg, h_last;
    logic                vgo, hgo, line_end;

    // Geometry for the captured device size.
    always_comb begin
        n_rows   = tall_q ? ROW_CW'(ROWS_TALL) : ROW_CW'(ROWS_SHORT);
        line_len = wide_q ? PIX_CW'(LINE_WIDE) : PIX_CW'(LINE_NARROW);
        eff_cols = wide_q ? PIX_CW'(EFF_COLS_WIDE) : PIX_CW'(EFF_COLS_NARROW);
        v_half   = VW_CW'(V_HALF_BASE) << ({1'b0, tall_q} + {1'b0, wide_q});
    end

    // Launch conditions for the two phase generators.
    always_comb begin
        line_end = h_last && (pix_cnt == line_len - 1'b1);
        vgo = ((state_q == ST_INTEG) && (icnt == '0))
           || ((state_q == ST_VXFER) && v_last && !area_q
               && (row_cnt != n_rows - 1'b1))
           || ((state_q == ST_HREAD) && line_end && area_q
               && (row_cnt != n_rows));
        hgo = ((state_q == ST_GAP) && (gcnt == '0))
           || ((state_q == ST_HREAD) && h_last && !line_end);
    end

    // Frame state machine with its row, pixel and delay counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            area_q  <= 1'b0;
            tall_q  <= 1'b0;
            wide_q  <= 1'b0;
            icnt    <= '0;
            row_cnt <= '0;
            pix_cnt <= '0;
            gcnt    <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    state_q <= ST_INTEG;
                    area_q  <= area_mode;
                    tall_q  <= tall_dev;
                    wide_q  <= wide_dev;
                    icnt    <= (integ_len == '0) ? '0 : integ_len - 1'b1;
                    row_cnt <= '0;
                    pix_cnt <= '0;
                end
                ST_INTEG: begin
                    if (icnt == '0) state_q <= ST_VXFER;
                    else            icnt    <= icnt - 1'b1;
                end
                ST_VXFER: if (v_last) begin
                    row_cnt <= row_cnt + 1'b1;
                    if (area_q || (row_cnt == n_rows - 1'b1)) begin
                        state_q <= ST_GAP;
                        gcnt    <= GAP_CW'(TG_GAP - 1);
                    end
                end
                ST_GAP: begin
                    if (gcnt == '0) begin
                        state_q <= ST_HREAD;
                        pix_cnt <= '0;
                    end else begin
                        gcnt <= gcnt - 1'b1;
                    end
                end
                ST_HREAD: if (h_last) begin
                    if (line_end) begin
                        pix_cnt <= '0;
                        if (!area_q || (row_cnt == n_rows)) state_q <= ST_DONE;
                        else                                state_q <= ST_VXFER;
                    end else begin
                        pix_cnt <= pix_cnt + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    ccd_vphase_gen #(.CW(VW_CW)) u_vgen (
        .clk    (clk),
        .rst_n  (rst_n),
        .go     (vgo),
        .half_w (v_half),
        .ph     (v_ph),
        .last   (v_last)
    );

    ccd_hphase_gen #(.HALF_W(H_HALF), .RG_W(RG_WIDTH)) u_hgen (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (hgo),
        .ph    (h_ph),
        .rg    (h_rg),
        .last  (h_last)
    );

    // Output mapping: complementary pairs and the follower gates.
    assign vclk_b       = v_ph;
    assign vclk_a       = !v_ph;
    assign xfer_gate    = v_ph;
    assign hclk_a       = h_ph;
    assign hclk_b       = !h_ph;
    assign sum_gate     = !h_ph;
    assign rst_gate     = h_rg;
    assign shutter_open = (state_q == ST_INTEG);
    assign frame_done   = (state_q == ST_DONE);
    assign pix_valid    = (state_q == ST_HREAD) && h_last
                       && (pix_cnt >= PIX_CW'(LEAD_DUMMY))
                       && (pix_cnt < PIX_CW'(LEAD_DUMMY) + eff_cols)
                       && (!area_q || (row_cnt > ROW_CW'(BEVEL_ROWS)));

    // R2
    shutter_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_INTEG) |-> (!v_ph && !h_ph));
    // R7
    bin_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!area_q && h_ph) |-> (row_cnt == n_rows));
    // R4
    row_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        row_cnt <= n_rows);
    // R9
    gap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GAP) |-> (!h_ph && !v_ph));
    // R11
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);
    // R12
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q != ST_IDLE) && ($past(state_q) != ST_IDLE))
        |-> ($stable(area_q) && $stable(tall_q) && $stable(wide_q)));
endmodule

// File: tb/ccd_clock_sequencer_test.sv
`timescale 1ns/1ps
module ccd_clock_sequencer_test;
    localparam int CN = 8, CW_ = 12, RS = 3, RT = 5, BV = 2;
    localparam int LD = 10, TD = 9, VB = 2, HH = 2, RGW = 1, GP = 3;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [7:0] integ_len = '0;
    logic area_mode = 1'b0, tall_dev = 1'b0, wide_dev = 1'b0;
    logic vclk_a, vclk_b, xfer_gate, hclk_a, hclk_b, sum_gate, rst_gate;
    logic shutter_open, pix_valid, frame_done;

    always #2 clk = ~clk;

    ccd_clock_sequencer #(
        .EFF_COLS_NARROW(CN), .EFF_COLS_WIDE(CW_), .EFF_ROWS_SHORT(RS),
        .EFF_ROWS_TALL(RT), .BEVEL_ROWS(BV), .LEAD_DUMMY(LD), .TRAIL_DUMMY(TD),
        .V_HALF_BASE(VB), .H_HALF(HH), .RG_WIDTH(RGW), .TG_GAP(GP), .INTEG_W(8)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .integ_len(integ_len),
        .area_mode(area_mode), .tall_dev(tall_dev), .wide_dev(wide_dev),
        .vclk_a(vclk_a), .vclk_b(vclk_b), .xfer_gate(xfer_gate),
        .hclk_a(hclk_a), .hclk_b(hclk_b), .sum_gate(sum_gate),
        .rst_gate(rst_gate), .shutter_open(shutter_open),
        .pix_valid(pix_valid), .frame_done(frame_done)
    );

    // {area, tall, wide, integ}
    localparam logic [10:0] VEC [0:7] = '{
        {3'b000, 8'd5},  {3'b010, 8'd12}, {3'b001, 8'd0},  {3'b011, 8'd1},
        {3'b100, 8'd7},  {3'b110, 8'd3},  {3'b101, 8'd20}, {3'b111, 8'd255}
    };

    int errors = 0, checks = 0;

    task automatic chk(input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Monitor state, sampled at negedges.
    bit mon_on = 0, cur_area = 0;
    int cur_line = 1;
    int sh_cnt, comp_err, shut_err, p2v_rises, p1h_rises, rg_rises, valid_cnt;
    int vrun, vw_min, vw_max, hrun, hw_min, hw_max, rgrun, rg_max;
    int tglow, gap_min, gap_max, first_v, last_v, vpos_err, order_err, bin_p2v;
    bit armed, pv2, ph1, prg;

    task automatic mon_clear();
        sh_cnt = 0; comp_err = 0; shut_err = 0; p2v_rises = 0; p1h_rises = 0;
        rg_rises = 0; valid_cnt = 0; vrun = 0; vw_min = 1 << 30; vw_max = 0;
        hrun = 0; hw_min = 1 << 30; hw_max = 0; rgrun = 0; rg_max = 0;
        tglow = 0; gap_min = 1 << 30; gap_max = 0; first_v = 0; last_v = 0;
        vpos_err = 0; order_err = 0; bin_p2v = -1; armed = 0;
        pv2 = 0; ph1 = 0; prg = 0;
    endtask

    always @(negedge clk) if (mon_on) begin
        if ((vclk_a !== ~vclk_b) || (xfer_gate !== vclk_b) ||
            (hclk_b !== ~hclk_a) || (sum_gate !== hclk_b)) comp_err++;
        if (shutter_open) sh_cnt++;
        if (shutter_open && (vclk_b || hclk_a)) shut_err++;
        if (hclk_a && !ph1) begin
            if (armed) begin
                if (tglow < gap_min) gap_min = tglow;
                if (tglow > gap_max) gap_max = tglow;
                armed = 0;
            end
            p1h_rises++;
            if (p1h_rises == 1) bin_p2v = p2v_rises;
        end
        if (hclk_a) hrun++;
        else if (ph1) begin
            if (hrun < hw_min) hw_min = hrun;
            if (hrun > hw_max) hw_max = hrun;
            hrun = 0;
        end
        if (vclk_b) begin
            if (!pv2) begin
                p2v_rises++;
                if (cur_area && (p1h_rises % cur_line != 0)) order_err++;
            end
            vrun++; tglow = 0;
        end else begin
            if (pv2) begin
                if (vrun < vw_min) vw_min = vrun;
                if (vrun > vw_max) vw_max = vrun;
                vrun = 0; armed = 1;
            end
            tglow++;
        end
        if (rst_gate) begin
            if (!prg) rg_rises++;
            rgrun++;
        end else begin
            if (rgrun > rg_max) rg_max = rgrun;
            rgrun = 0;
        end
        if (pix_valid) begin
            valid_cnt++;
            if (first_v == 0) first_v = p1h_rises;
            last_v = p1h_rises;
            if (hclk_a) vpos_err++;
        end
        pv2 = vclk_b; ph1 = hclk_a; prg = rst_gate;
    end

    int cyc;

    // Run one frame; with disturb, toggle start and the selects mid-frame.
    task automatic run_frame(input bit a, input bit t, input bit w,
                             input logic [7:0] il, input bit disturb);
        @(negedge clk);
        area_mode = a; tall_dev = t; wide_dev = w; integ_len = il;
        cur_area = a; cur_line = LD + (w ? CW_ : CN) + TD + 1;
        mon_clear(); mon_on = 1; start = 1;
        @(negedge clk);
        start = 0; cyc = 1;
        while (!frame_done && cyc < 5000) begin
            @(negedge clk);
            cyc++;
            if (disturb && cyc == 40) begin
                start = 1; area_mode = ~a; tall_dev = ~t; wide_dev = ~w;
            end
            if (disturb && cyc == 41) start = 0;
        end
        mon_on = 0;
        area_mode = a; tall_dev = t; wide_dev = w;
    endtask

    task automatic check_frame(input bit a, input bit t, input bit w,
                               input int il);
        int rows, line, eff, effr, vw, l, pix, frame;
        rows = (t ? RT : RS) + BV;
        effr = t ? RT : RS;
        eff = w ? CW_ : CN;
        line = LD + eff + TD + 1;
        vw = VB << (int'(t) + int'(w));
        l = (il == 0) ? 1 : il;
        pix = a ? rows * line : line;
        frame = a ? l + rows * (2 * vw + GP + 2 * HH * line) + 1
                  : l + rows * 2 * vw + GP + 2 * HH * line + 1;
        chk("R2", "shutter cycles", sh_cnt, l);
        chk("R2", "shutter with clocks", shut_err, 0);
        chk("R3", "pair/follower mismatches", comp_err, 0);
        chk("R4", "vertical transfers", p2v_rises, rows);
        chk("R4", "vclk_b min width", vw_min, vw);
        chk("R4", "vclk_b max width", vw_max, vw);
        chk("R5", "hclk_a rises", p1h_rises, pix);
        chk("R5", "hclk_a high min", hw_min, HH);
        chk("R5", "hclk_a high max", hw_max, HH);
        chk("R6", "rst_gate pulses", rg_rises, pix);
        chk("R6", "rst_gate width", rg_max, RGW);
        chk("R9", "gap min", gap_min, vw + GP);
        chk("R9", "gap max", gap_max, vw + GP);
        chk("R10", "valid count", valid_cnt, a ? effr * eff : eff);
        chk("R10", "first valid index", first_v, (a ? BV * line : 0) + LD + 1);
        chk("R10", "last valid index", last_v, (a ? (rows - 1) * line : 0) + LD + eff);
        chk("R10", "valid during hclk_a high", vpos_err, 0);
        chk("R11", "frame length", cyc, frame);
        if (a) chk("R8", "transfer not on line boundary", order_err, 0);
        else   chk("R7", "transfers before readout", bin_p2v, rows);
    endtask

    function automatic logic [9:0] outs();
        return {vclk_a, vclk_b, xfer_gate, hclk_a, hclk_b, sum_gate,
                rst_gate, shutter_open, pix_valid, frame_done};
    endfunction
    localparam logic [9:0] IDLE_OUT = 10'b1000110000;

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "outputs in reset", outs(), IDLE_OUT);
        rst_n = 1;
        @(negedge clk);
        chk("R1", "outputs after reset", outs(), IDLE_OUT);

        for (int i = 0; i < 8; i++) begin
            run_frame(VEC[i][10], VEC[i][9], VEC[i][8], VEC[i][7:0], 1'b0);
            check_frame(VEC[i][10], VEC[i][9], VEC[i][8], int'(VEC[i][7:0]));
            @(negedge clk);
            chk("R11", "done one cycle", frame_done, 0);
            chk("R1", "idle after frame", outs(), IDLE_OUT);
        end

        // R12: start and selects toggled mid-frame have no effect.
        run_frame(1'b0, 1'b0, 1'b0, 8'd5, 1'b1);
        check_frame(1'b0, 1'b0, 1'b0, 5);
        begin
            int extra;
            extra = 0;
            for (int k = 0; k < 60; k++) begin
                @(negedge clk);
                if (shutter_open || frame_done) extra++;
            end
            chk("R12", "activity after disturbed frame", extra, 0);
        end

        // R1: reset in mid-readout returns to idle on the next clock.
        @(negedge clk);
        area_mode = 1; tall_dev = 0; wide_dev = 0; integ_len = 8'd2; start = 1;
        @(negedge clk);
        start = 0;
        repeat (60) @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        chk("R1", "outputs after mid-frame reset", outs(), IDLE_OUT);
        rst_n = 1;
        begin
            int act;
            act = 0;
            for (int k = 0; k < 40; k++) begin
                @(negedge clk);
                if (outs() != IDLE_OUT) act++;
            end
            chk("R1", "stays idle after reset", act, 0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL R11 watchdog: actual=%0d expected=%0d", 200000, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule